// File: doc/BRIEF.md
# Multi-Channel Reloading Down-Counter Timer

This block holds several independent 32-bit timer channels behind one small synchronous register bus. Each channel decrements its counter once per prescaled tick of the peripheral clock. When a tick finds the counter already at zero, the counter takes the channel's reload value and a sticky underflow flag is set. A channel's interrupt line is a level that is high while that flag and the channel's interrupt enable are both set.

A shared run register has one bit per channel and starts or freezes each counter. The reload value selects the mode. A non-zero value gives a periodic tick source. Zero gives a one-shot that parks at zero after the first underflow. Software clears the flag by writing 0 to its bit. Writing 1 to it does nothing.

Top module: `dct_timer`

## Requirements
- R1: After reset, every register reads 0 and every interrupt output is low.
- R2: The run register is at byte address 0x00. Bit n runs channel n. While bit n is 0, channel n's counter holds its value. Bits at or above the channel count read back as 0.
- R3: On each prescaled tick, a running counter decrements by one. A tick that finds the counter at 0 loads the reload register instead.
- R4: Control bit 8 is the underflow flag. It is set on the tick that reloads, and it stays set until software clears it.
- R5: A control write with bit 8 at 0 clears the flag, and a write with bit 8 at 1 leaves it unchanged. If an underflow and a clear fall in the same cycle, the flag is set.
- R6: Control bit 5 is the interrupt enable. Output irq[n] is high exactly while channel n's flag and enable are both 1.
- R7: Control bits [2:0] select the prescale divisor: 4, 16, 64 and 256 for values 0 to 3, and 4 for values 4 to 7. The first tick comes one full divisor period after the start. The prescaler is held at phase zero while the channel is stopped.
- R8: With a reload value of 0, the counter stays at 0 after its first underflow (one-shot).
- R9: A bus write to the counter takes effect at the next clock edge and restarts the prescale phase. The next decrement therefore comes one full divisor period after the write.
- R10: Channel n's registers start at byte 0x04 + 0xC*n, in the order counter (+0), reload (+4), control (+8). Read data is combinational from the address. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 3 | Per-channel interrupt level |

## Verification
The hardest case to reach from the ports is the prescale phase restart on a counter write. Old and new phases differ by only a cycle or two, so a loose bench can miss a fault there. The stimulus runs a channel from a known start edge, so the bench knows every tick edge. It then writes the counter exactly one cycle before a tick that would be due without the restart. It reads the counter at the edge where the old phase would already show a decrement and the new phase would not. Underflow reloads, the one-shot parking at zero and the divide-by-16 timing are placed on exact edges in the same way.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned CW        = 32;
  localparam int unsigned PW        = 8;
  localparam int unsigned FLAG_BIT  = 8;
  localparam int unsigned IE_BIT    = 5;
  localparam int unsigned START_ADR = 0;
  localparam int unsigned CH_BASE   = 4;
  localparam int unsigned CH_STRIDE = 12;

  // last prescale phase index: divisor 4 << (2*sel), selectors above 3 fold to 4
  function automatic logic [PW-1:0] last_phase(input logic [2:0] sel);
    logic [PW:0] div;
    div = (sel > 3'd3) ? (PW+1)'(4) : ((PW+1)'(4) << {sel[1:0], 1'b0});
    return PW'(div - (PW+1)'(1));
  endfunction

  // next counter value on a tick
  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cur,
                                               input logic [CW-1:0] rel);
    return (cur == '0) ? rel : cur - CW'(1);
  endfunction
endpackage

// File: rtl/dct_prescale.sv
module dct_prescale
  import dct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PW-1:0] phase_q;
  logic [PW-1:0] last;

  assign last = last_phase(sel);
  assign tick = run && !restart && (phase_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart || tick) phase_q <= '0;
    else                                   phase_q <= phase_q + PW'(1);
  end
endmodule

// File: rtl/dct_channel.sv
module dct_channel
  import dct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr_cnt,
  input  logic          wr_rel,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rel,
  output logic [CW-1:0] ctl_rd,
  output logic          tick,
  output logic          uflow,
  output logic          flag,
  output logic          ie,
  output logic          clr,
  output logic          irq
);
  logic [2:0] sel_q;

  dct_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(wr_cnt),
    .sel(sel_q), .tick(tick)
  );

  assign uflow  = tick && !wr_cnt && (cnt == '0);
  assign clr    = wr_ctl && !wdata[FLAG_BIT];
  assign irq    = flag && ie;
  assign ctl_rd = {23'b0, flag, 2'b0, ie, 2'b0, sel_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      rel   <= '0;
      sel_q <= '0;
      ie    <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (wr_cnt)     cnt <= wdata;
      else if (tick)  cnt <= next_count(cnt, rel);
      if (wr_rel) rel <= wdata;
      if (wr_ctl) begin
        sel_q <= wdata[2:0];
        ie    <= wdata[IE_BIT];
      end
      if (uflow)    flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dct_timer.sv
module dct_timer
  import dct_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0]         run_q;
  logic [NCH-1:0][CW-1:0] cnt_w, rel_w, ctl_w;
  logic [NCH-1:0]         hit_cnt, hit_rel, hit_ctl;
  logic [NCH-1:0]         tick_w, uflow_w, flag_w, ie_w, clr_w, wrcnt_w;
  logic                   hit_run, wr;

  assign wr      = bus_sel && bus_we;
  assign hit_run = (bus_addr == AW'(START_ADR));

  always_ff @(posedge clk) begin
    if (!rst_n)            run_q <= '0;
    else if (wr && hit_run) run_q <= bus_wdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int unsigned BASE = CH_BASE + i * CH_STRIDE;
    assign hit_cnt[i] = (bus_addr == AW'(BASE));
    assign hit_rel[i] = (bus_addr == AW'(BASE + 4));
    assign hit_ctl[i] = (bus_addr == AW'(BASE + 8));
    assign wrcnt_w[i] = wr && hit_cnt[i];

    dct_channel u_ch (
      .clk(clk), .rst_n(rst_n), .run(run_q[i]),
      .wr_cnt(wrcnt_w[i]), .wr_rel(wr && hit_rel[i]), .wr_ctl(wr && hit_ctl[i]),
      .wdata(bus_wdata), .cnt(cnt_w[i]), .rel(rel_w[i]), .ctl_rd(ctl_w[i]),
      .tick(tick_w[i]), .uflow(uflow_w[i]), .flag(flag_w[i]), .ie(ie_w[i]),
      .clr(clr_w[i]), .irq(irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_run) bus_rdata = 32'(run_q);
    for (int i = 0; i < NCH; i++) begin
      if (hit_cnt[i]) bus_rdata = cnt_w[i];
      if (hit_rel[i]) bus_rdata = rel_w[i];
      if (hit_ctl[i]) bus_rdata = ctl_w[i];
    end
  end
endmodule

// File: rtl/dct_timer_chk.sv
module dct_timer_chk #(
  parameter int unsigned NCH = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCH-1:0]      irq,
  input logic [NCH-1:0]      run,
  input logic [NCH-1:0]      tick,
  input logic [NCH-1:0]      uflow,
  input logic [NCH-1:0]      flag,
  input logic [NCH-1:0]      ie,
  input logic [NCH-1:0]      clr,
  input logic [NCH-1:0]      wrcnt,
  input logic [NCH-1:0][31:0] cnt
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] == (flag[i] && ie[i]));
    p_uflow_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      uflow[i] |=> flag[i]);
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i]) |=> flag[i]);
    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !wrcnt[i]) |=> $stable(cnt[i]));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && !wrcnt[i] && cnt[i] != 32'd0) |=> cnt[i] == $past(cnt[i]) - 32'd1);
    p_tick_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick[i] |-> run[i]);
    p_cnt_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wrcnt[i] |-> !tick[i]);
  end
endmodule

bind dct_timer dct_timer_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .run(run_q), .tick(tick_w),
  .uflow(uflow_w), .flag(flag_w), .ie(ie_w), .clr(clr_w), .wrcnt(wrcnt_w),
  .cnt(cnt_w)
);

// File: tb/dct_timer_tb_top.sv
module dct_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  dct_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: pops expected read data as each read happens
  always @(posedge clk) begin
    if (bus_sel && !bus_we && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s addr=%02h actual=%08h expected=%08h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic [2:0] e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, 32'h0, "R1 run reg");
    rd(8'h04, 32'h0, "R1 ch0 counter");
    rd(8'h0C, 32'h0, "R1 ch0 control");
    rd(8'h20, 32'h0, "R1 ch2 reload");
    chk_irq(3'b000, "R1 irq");

    // R2 stopped channel holds
    wr(8'h04, 32'd5);
    wr(8'h08, 32'd5);
    wr(8'h0C, 32'h20);
    idle(20);
    rd(8'h04, 32'd5, "R2 stopped counter held");

    // ch0 periodic, divide-by-4
    wr(8'h00, 32'h1);                       // edge Ew
    idle(8);
    rd(8'h04, 32'd3, "R3 two ticks after start");   // Ew+9
    idle(15);
    rd(8'h04, 32'd5, "R3 reload after underflow");  // Ew+25
    rd(8'h0C, 32'h120, "R4 flag set");              // Ew+26
    chk_irq(3'b001, "R6 irq with flag and enable");
    wr(8'h0C, 32'h120);                             // Ew+27
    rd(8'h0C, 32'h120, "R5 writing 1 keeps flag");  // Ew+28
    wr(8'h0C, 32'h020);                             // Ew+29
    rd(8'h0C, 32'h020, "R5 writing 0 clears flag"); // Ew+30
    chk_irq(3'b000, "R6 irq low after clear");
    wr(8'h00, 32'h0);                               // Ew+31
    idle(10);
    rd(8'h04, 32'd4, "R2 counter frozen after stop");

    // ch1 one-shot, divide-by-16
    wr(8'h14, 32'd0);
    wr(8'h10, 32'd2);
    wr(8'h18, 32'h21);
    wr(8'h00, 32'h2);                               // Es
    idle(15);
    rd(8'h10, 32'd2, "R7 no tick before 16 cycles"); // Es+16
    rd(8'h10, 32'd1, "R7 tick at 16 cycles");        // Es+17
    idle(31);
    rd(8'h18, 32'h121, "R4 one-shot underflow flag"); // Es+49
    chk_irq(3'b010, "R6 ch1 irq");
    rd(8'h10, 32'd0, "R8 one-shot at zero");
    idle(40);
    rd(8'h10, 32'd0, "R8 one-shot stays zero");

    // ch2 selector 5 acts as divide-by-4, interrupt disabled
    wr(8'h1C, 32'd10);
    wr(8'h20, 32'd7);
    wr(8'h24, 32'h005);
    wr(8'h00, 32'h4);                               // Es2
    idle(8);
    rd(8'h1C, 32'd8, "R7 selector 5 divides by 4");  // Es2+9
    idle(35);
    rd(8'h24, 32'h105, "R4 ch2 flag with enable off"); // Es2+45
    chk_irq(3'b010, "R6 ch2 irq stays low without enable");
    rd(8'h1C, 32'd7, "R3 ch2 reload value");         // Es2+46

    // R9 counter write restarts prescale phase
    wr(8'h1C, 32'd100);                              // Ew3
    rd(8'h1C, 32'd100, "R9 write visible next clock");
    idle(2);
    rd(8'h1C, 32'd100, "R9 no tick before full period");
    rd(8'h1C, 32'd99, "R9 tick one period after write");

    // R10 map and readback
    rd(8'h00, 32'h4, "R10 run reg readback");
    rd(8'h08, 32'd5, "R10 ch0 reload address");
    rd(8'h30, 32'h0, "R10 unmapped address");
    wr(8'h00, 32'hFF);
    rd(8'h00, 32'h7, "R2 unused run bits read 0");

    idle(2);
    done = 1'b1;
    report();
  end
endmodule